// File: doc/BRIEF.md
# Two-Wire Slave for Setup Registers and Byte Array

This block is the serial front end of a supervisory chip. It answers on a two-wire bus (I2C timing, open-drain data) and gives the bus master access to two targets. One is a bank of eight setup registers. The other is a 512-byte array, which stands in for nonvolatile storage.

The system clock oversamples the bus lines. The block decodes the address byte that follows each start condition. It supports these transfers:

- single-byte and 16-byte page writes;
- current-address, random and sequential reads.

After every write transaction the block imitates the programming time of real nonvolatile cells. For a fixed number of clocks it stays off the bus, so software can poll it until it answers again.

The last register of the bank has two roles:

- One bit selects which of two device-type codes reaches the array.
- One bit, once set, closes the register bank to the bus until the next reset.

Top module: `i2cnv_slave`

## Requirements
- R1: The address byte is read MSB first. Bits 7:4 are the device type, bits 3:2 must equal `bus_sel`, bit 1 is array address bit 8, and bit 0 is 1 for a read and 0 for a write. The block acknowledges only when the pins match and the type is currently enabled. Otherwise it leaves data released and ignores the bus until the next start.
- R2: An array write takes a word-address byte and then data. The byte goes to the 9-bit location {address-byte bit 1, word address}. A random read (write of the word address, repeated start, read) returns that byte.
- R3: During an array write only the low 4 address bits advance after each acknowledged byte. A write that runs past the end of a 16-byte page wraps to the page start and overwrites earlier bytes.
- R4: During a read the full 9-bit pointer advances after each byte, and location 0x1FF is followed by 0x000. A master acknowledge requests another byte. A master no-acknowledge ends the transfer.
- R5: A read that has no word-address phase returns the byte at the last accessed location plus one.
- R6: A stop that follows at least one acknowledged data byte starts a busy window of `WR_CYCLES` clocks. During that window start conditions are ignored and nothing is acknowledged. A stop that follows only address bytes starts no window.
- R7: Type 1001 reaches the register bank, indexed by the low 3 bits of the word address. In register 7, bits 5:0 always read 0 and writes to them are dropped.
- R8: Register 7 bit 6 selects the array code: 1010 when the bit is 0, 1011 when it is 1. The array does not acknowledge the other code.
- R9: Once register 7 bit 7 is set, type 1001 is never acknowledged again until reset. Array access is unaffected.
- R10: A register write stores one data byte. Any further data byte in the same transfer is not acknowledged and is not stored.
- R11: After reset the data line is released and every register reads 0.
- R12: The block changes its data drive only while the clock is low. While the clock is high it pulls data low only in an acknowledge slot or a read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| bus_sel | input | 2 | Strapped bus address, compared with address bits 3:2 |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Two events can land in the same cycle: the stop that closes a write, which launches the busy window, and the start detection of the master's next poll. The bench provokes this by issuing a new start and address right after a write's stop. It expects no acknowledge, then an acknowledge once the window has run out.

The page-wrap increment and the byte write also share one cycle at the last byte of a page. The bench writes 18 bytes across a page boundary and reads the whole page back against its behavioural model of the array.

// File: rtl/i2cnv_pkg.sv
package i2cnv_pkg;
  localparam int MEM_AW   = 9;          // word address byte plus one bit from the address byte
  localparam int MEM_SIZE = 1 << MEM_AW;

  localparam logic [3:0] TYPE_REGS = 4'b1001;
  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_ALT  = 4'b1011;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RDAT
  } phase_t;
endpackage

// File: rtl/i2cnv_line_sync.sv
module i2cnv_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
    end
  end

  assign scl_o     = scl_q[1];
  assign sda_o     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_p;
  assign scl_fall  = ~scl_q[1] & scl_p;
  assign start_det = scl_q[1] & scl_p & sda_p & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_p & ~sda_p & sda_q[1];
endmodule

// File: rtl/i2cnv_store.sv
module i2cnv_store
  import i2cnv_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_we,
  input  logic              reg_we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        mem_rdata,
  output logic [7:0]        reg_rdata,
  output logic              lock_o,
  output logic              alt_o
);
  localparam int REG_AW = $clog2(NREG);
  localparam int LAST   = NREG - 1;

  logic [7:0] mem  [MEM_SIZE];
  logic [7:0] regs [NREG];

  // array: one write port, registered read, no reset (block RAM friendly)
  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= wdata;
    mem_rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (reg_we) begin
      if (addr[REG_AW-1:0] == REG_AW'(LAST))
        regs[LAST] <= {regs[LAST][7] | wdata[7], wdata[6], 6'b0};
      else
        regs[addr[REG_AW-1:0]] <= wdata;
    end
  end

  assign reg_rdata = regs[addr[REG_AW-1:0]];
  assign lock_o    = regs[LAST][7];
  assign alt_o     = regs[LAST][6];

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> lock_o);
endmodule

// File: rtl/i2cnv_wr_timer.sv
module i2cnv_wr_timer #(
  parameter int WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (kick)        cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  a_r6_kick_busy: assert property (@(posedge clk) disable iff (rst)
    kick |=> busy);
endmodule

// File: rtl/i2cnv_slave.sv
module i2cnv_slave
  import i2cnv_pkg::*;
#(
  parameter int WR_CYCLES = 250000,
  parameter int PAGE_AW   = 4,
  parameter int NREG      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] bus_sel,
  output logic       sda_pull_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, kick, lock, alt;
  logic mem_we, reg_we;
  logic [7:0] mem_rdata, reg_rdata, rd_byte;

  phase_t            phase;
  logic [3:0]        bit_cnt;
  logic              in_ack, is_read, sel_reg, reg_done, wrote, a8, sda_pull;
  logic [7:0]        shreg, tx;
  logic [MEM_AW-1:0] ptr;

  i2cnv_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cnv_store #(.NREG(NREG)) u_store (
    .clk(clk), .rst(rst), .mem_we(mem_we), .reg_we(reg_we), .addr(ptr),
    .wdata(shreg), .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
    .lock_o(lock), .alt_o(alt)
  );

  i2cnv_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy)
  );

  // address byte decode
  logic [3:0] mem_code;
  logic       pins_ok, hit_mem, hit_reg, byte_done;
  assign mem_code  = alt ? TYPE_ALT : TYPE_MEM;
  assign pins_ok   = (shreg[3:2] == bus_sel);
  assign hit_mem   = (shreg[7:4] == mem_code);
  assign hit_reg   = (shreg[7:4] == TYPE_REGS) && !lock;
  assign byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8);

  assign mem_we  = byte_done && (phase == PH_WDAT) && !sel_reg;
  assign reg_we  = byte_done && (phase == PH_WDAT) && sel_reg && !reg_done;
  assign kick    = stop_det && wrote;
  assign rd_byte = sel_reg ? reg_rdata : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      is_read  <= 1'b0;
      sel_reg  <= 1'b0;
      reg_done <= 1'b0;
      wrote    <= 1'b0;
      a8       <= 1'b0;
      sda_pull <= 1'b0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
    end else if (start_det) begin
      if (!busy) begin
        phase    <= PH_DEV;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        reg_done <= 1'b0;
        sda_pull <= 1'b0;
      end
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      in_ack   <= 1'b0;
      wrote    <= 1'b0;
      sda_pull <= 1'b0;
    end else if (phase == PH_RDAT) begin
      if (scl_rise && in_ack && sda_s) begin
        phase <= PH_IDLE;                          // master NACK ends the read
      end else if (scl_fall && !in_ack) begin
        if (bit_cnt == 4'd7) begin
          sda_pull <= 1'b0;
          in_ack   <= 1'b1;
          ptr      <= ptr + 1'b1;                  // full-width increment
        end else begin
          tx       <= {tx[6:0], 1'b0};
          sda_pull <= ~tx[6];
          bit_cnt  <= bit_cnt + 1'b1;
        end
      end else if (scl_fall && in_ack) begin
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
        tx       <= rd_byte;
        sda_pull <= ~rd_byte[7];
      end
    end else if (phase != PH_IDLE) begin
      if (scl_rise && !in_ack) begin
        shreg   <= {shreg[6:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (byte_done) begin
        case (phase)
          PH_DEV: begin
            if (pins_ok && (hit_mem || hit_reg)) begin
              is_read  <= shreg[0];
              sel_reg  <= hit_reg;
              a8       <= shreg[1];
              in_ack   <= 1'b1;
              sda_pull <= 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_WADR: begin
            ptr      <= {a8, shreg};
            in_ack   <= 1'b1;
            sda_pull <= 1'b1;
          end
          default: begin                           // PH_WDAT
            if (sel_reg && reg_done) begin
              phase <= PH_IDLE;
            end else begin
              in_ack   <= 1'b1;
              sda_pull <= 1'b1;
              wrote    <= 1'b1;
              reg_done <= sel_reg;
              if (sel_reg) ptr <= ptr + 1'b1;
              else         ptr <= {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
            end
          end
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        if (phase == PH_DEV) begin
          if (is_read) begin
            phase    <= PH_RDAT;
            tx       <= rd_byte;
            sda_pull <= ~rd_byte[7];
          end else begin
            phase <= PH_WADR;
          end
        end else if (phase == PH_WADR) begin
          phase <= PH_WDAT;
        end
      end
    end
  end

  assign sda_pull_o = sda_pull;

  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull);

  a_r12_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_s);

  a_r3_page_kept: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW]));
endmodule

// File: tb/i2cnv_slave_tb.sv
module i2cnv_slave_tb;
  localparam int WR = 300;
  localparam int Q  = 6;

  logic       clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] pins = 2'b10;
  logic       sda_pull;
  logic       sda_line;
  assign sda_line = m_sda & ~sda_pull;

  always #10 clk = ~clk;

  i2cnv_slave #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .bus_sel(pins), .sda_pull_o(sda_pull)
  );

  int n_tests = 0, n_fail = 0, r12_viol = 0;
  bit may_drive = 0, done = 0;
  logic [7:0] mem_m [512];
  logic [7:0] reg_m [8];
  int ptr_m = 0;
  logic [7:0] wq [$];
  logic [7:0] rq [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic v, output logic s);
    m_sda = v; hold(Q);
    scl = 1'b1; hold(Q);
    s = sda_line; hold(Q);
    scl = 1'b0;
  endtask

  task automatic i2c_start;
    may_drive = 0;
    m_sda = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop;
    may_drive = 0;
    m_sda = 1'b0; hold(Q);
    scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    logic s;
    may_drive = 0;
    for (int i = 7; i >= 0; i--) bitx(b[i], s);
    may_drive = 1;
    bitx(1'b1, s);
    ack = !s;
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    logic s;
    may_drive = 1;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, s);
      b[i] = s;
    end
    may_drive = 0;
    bitx(mack ? 1'b0 : 1'b1, s);
  endtask

  function automatic logic [7:0] devb(input logic [3:0] t, input logic a8, input logic rd);
    return {t, pins, a8, rd};
  endfunction

  // write transfer: address byte, word address, bytes from wq; returns acked data count
  task automatic wr_tx(input logic [3:0] t, input logic [8:0] a, input string tag, output int nacks);
    bit ack;
    i2c_start;
    send(devb(t, a[8], 1'b0), ack); chk({tag, " addr ack"}, ack, 1);
    send(a[7:0], ack);             chk({tag, " word ack"}, ack, 1);
    nacks = 0;
    foreach (wq[i]) begin
      send(wq[i], ack);
      if (ack) nacks++;
    end
    i2c_stop;
  endtask

  task automatic rd_tx(input logic [3:0] t, input bit rnd, input logic [8:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    rq.delete();
    i2c_start;
    if (rnd) begin
      send(devb(t, a[8], 1'b0), ack); chk({tag, " addr ack"}, ack, 1);
      send(a[7:0], ack);             chk({tag, " word ack"}, ack, 1);
      i2c_start;
    end
    send(devb(t, 1'b0, 1'b1), ack);  chk({tag, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      rq.push_back(b);
    end
    i2c_stop;
  endtask

  task automatic probe(input logic [3:0] t, input logic [1:0] pv, output bit ack);
    i2c_start;
    send({t, pv, 2'b00}, ack);
    i2c_stop;
  endtask

  task automatic model_mem_write(input int a);
    int p = a;
    foreach (wq[i]) begin
      mem_m[p] = wq[i];
      p = (p & 'h1F0) | ((p + 1) & 'hF);
    end
    ptr_m = p;
  endtask

  task automatic check_mem_read(input int a, input string tag);
    int p = a;
    foreach (rq[i]) begin
      chk(tag, rq[i], mem_m[p]);
      p = (p + 1) % 512;
    end
    ptr_m = p;
  endtask

  task automatic settle;
    hold(WR + 40);
  endtask

  // scan on every clock: no pull while scl is high outside slave slots (R12)
  always @(negedge clk)
    if (!rst && scl && !may_drive && sda_pull) r12_viol++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    int nd;
    for (int i = 0; i < 8; i++) reg_m[i] = 8'h00;
    hold(5); rst = 1'b0; hold(5);

    // R11: reset state
    chk("R11 sda released after reset", sda_pull, 0);
    rd_tx(4'b1001, 1, 9'h003, 1, "R11");
    chk("R11 register 3 reset value", rq[0], 8'h00);

    // R1: pin mismatch and unknown type are not acknowledged
    probe(4'b1010, 2'b01, ack); chk("R1 wrong bus pins nack", ack, 0);
    probe(4'b1100, pins, ack);  chk("R1 unknown type nack", ack, 0);
    probe(4'b1010, pins, ack);  chk("R1 matching address ack", ack, 1);

    // R2: byte writes with address bit 8 from the address byte
    wq = '{8'h3C}; wr_tx(4'b1010, 9'h1A5, "R2", nd); chk("R2 data ack", nd, 1);
    model_mem_write(9'h1A5); settle;
    wq = '{8'hC3}; wr_tx(4'b1010, 9'h0A5, "R2", nd); model_mem_write(9'h0A5); settle;
    rd_tx(4'b1010, 1, 9'h1A5, 1, "R2"); check_mem_read(9'h1A5, "R2 read 1A5");
    rd_tx(4'b1010, 1, 9'h0A5, 1, "R2"); check_mem_read(9'h0A5, "R2 read 0A5");

    // R6: poll during the busy window, then after it
    wq = '{8'h11}; wr_tx(4'b1010, 9'h000, "R6", nd); model_mem_write(0);
    probe(4'b1010, pins, ack); chk("R6 no ack while busy", ack, 0);
    settle;
    probe(4'b1010, pins, ack); chk("R6 ack after window", ack, 1);
    wq = '{8'h22}; wr_tx(4'b1010, 9'h1FF, "R6", nd); model_mem_write(9'h1FF); settle;
    wq.delete(); wr_tx(4'b1010, 9'h010, "R6", nd); ptr_m = 9'h010;
    probe(4'b1010, pins, ack); chk("R6 address-only stop leaves bus open", ack, 1);

    // R3: 18-byte page write from 0x03E wraps inside 0x030..0x03F
    wq.delete();
    for (int i = 0; i < 18; i++) wq.push_back(8'h50 + 8'(i));
    wr_tx(4'b1010, 9'h03E, "R3", nd); chk("R3 all page bytes acked", nd, 18);
    model_mem_write(9'h03E); settle;
    rd_tx(4'b1010, 1, 9'h030, 16, "R3"); check_mem_read(9'h030, "R3 page contents");

    // R4: sequential read wraps from 0x1FF to 0x000
    rd_tx(4'b1010, 1, 9'h1FF, 2, "R4"); check_mem_read(9'h1FF, "R4 wrap read");

    // R5: current-address read follows the last access
    rd_tx(4'b1010, 1, 9'h03A, 1, "R5"); check_mem_read(9'h03A, "R5 random");
    rd_tx(4'b1010, 0, 9'h000, 1, "R5"); check_mem_read(ptr_m, "R5 current address");

    // R7: register bank indexed by low 3 bits
    wq = '{8'h5A}; wr_tx(4'b1001, 9'h002, "R7", nd); reg_m[2] = 8'h5A; settle;
    wq = '{8'h99}; wr_tx(4'b1001, 9'h00D, "R7", nd); reg_m[5] = 8'h99; settle;
    rd_tx(4'b1001, 1, 9'h002, 1, "R7"); chk("R7 register 2", rq[0], reg_m[2]);
    rd_tx(4'b1001, 1, 9'h005, 1, "R7"); chk("R7 register 5 via low bits", rq[0], reg_m[5]);

    // R10: a second register data byte is refused and dropped
    wq = '{8'h12, 8'h34}; wr_tx(4'b1001, 9'h001, "R10", nd); settle;
    chk("R10 only one data byte acked", nd, 1);
    reg_m[1] = 8'h12;
    rd_tx(4'b1001, 1, 9'h001, 1, "R10"); chk("R10 register 1", rq[0], reg_m[1]);
    rd_tx(4'b1001, 1, 9'h002, 1, "R10"); chk("R10 register 2 untouched", rq[0], reg_m[2]);

    // R7 + R8: register 7 read-only bits and alternate array code
    wq = '{8'h7F}; wr_tx(4'b1001, 9'h007, "R8", nd); settle;
    rd_tx(4'b1001, 1, 9'h007, 1, "R7"); chk("R7 register 7 low bits read 0", rq[0], 8'h40);
    probe(4'b1010, pins, ack); chk("R8 default code refused", ack, 0);
    rd_tx(4'b1011, 1, 9'h1A5, 1, "R8"); check_mem_read(9'h1A5, "R8 alternate code read");

    // R9: lock closes the register bank, array stays reachable
    wq = '{8'hC0}; wr_tx(4'b1001, 9'h007, "R9", nd); settle;
    probe(4'b1001, pins, ack); chk("R9 registers refused when locked", ack, 0);
    rd_tx(4'b1011, 1, 9'h0A5, 1, "R9"); check_mem_read(9'h0A5, "R9 array after lock");

    chk("R12 no pull while scl high outside slots", r12_viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule